// File: doc/BRIEF.md
# Perceptual LED PWM Dimmer

This block drives one LED with a pulse-width-modulated signal whose on-time follows a 4-bit brightness request. The request does not map linearly onto on-time. A fixed lookup maps each of the 16 levels to an 8-bit duty value, and the table is shaped so that equal steps in the request look like roughly equal steps in brightness to the eye. A free-running 256-step period counter is compared against the duty value. The LED is driven high from the start of each period until the counter reaches the duty value.

Software or a neighbouring block presents a new level together with a one-cycle strobe. The block captures the value at once but does not use it until the current period has finished. Every period is therefore produced entirely at one level, and no truncated or stretched pulse ever reaches the LED. The top level of the table is handled as a special case: level 15 holds the output high for all 256 steps, instead of the 255/256 that the comparison alone could give. A pulse marks the first step of each period.

Top module: `led_dimmer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the counter and the active level are both cleared. In the cycle that follows, `led_out` is 0 and `period_start` is 1.
- R2: The period counter advances by one on every clock, from 0 to 255, and wraps to 0. `period_start` is 1 exactly in the cycles where the counter is 0, which is once every 256 cycles.
- R3: For an active level L in 1..14, `led_out` is 1 in the first duty(L) steps of each period (counter below duty(L)) and 0 in the remaining steps.
- R4: Level 0 keeps `led_out` at 0 for all 256 steps of the period.
- R5: Level 15 keeps `led_out` at 1 for all 256 steps of the period.
- R6: duty(1) = 1 and duty(14) = 217.
- R7: duty for levels 2 through 13 is 3, 6, 10, 16, 24, 34, 47, 64, 86, 113, 145, 178, in that order, so the table strictly increases from level 1 to level 14.
- R8: A strobe captures `level_in` in its own cycle. The captured level is active from the next cycle in which the counter is 0, and the output for the rest of the current period keeps following the old level.
- R9: If several strobes arrive within one period, the level of the last one is the one applied at the next period start.
- R10: A strobe that arrives in the final step (counter 255) is applied at the period start that immediately follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| level_in | input | 4 | Requested brightness level, 0..15 |
| level_stb | input | 1 | One-cycle strobe; when it is high, `level_in` is captured |
| led_out | output | 1 | PWM drive for the LED |
| period_start | output | 1 | High during the first step of each PWM period |

## Verification
A counter that drifts or skips a value moves `period_start` away from its 256-cycle spacing within one period. It also shifts the falling edge of `led_out` for any mid-range level. A wrong table entry shows up as a falling edge at the wrong step during the first period spent at that level. A level that is applied too early or too late shows up within one cycle of the period boundary, as an edge that appears while the old period is still running or that is missing at the new period's first step. The bench therefore compares both outputs against a reference on every cycle. It steers strobes onto the last step of a period, onto repeated strobes within one period, and across every level.

// File: rtl/dim_pkg.sv
// Package dim_pkg
// Shared widths and the perceptual duty table for the LED dimmer.
// Assumes a 4-bit level and an 8-bit duty; the table is fixed at build time.
package dim_pkg;

    localparam int LVL_W  = 4;
    localparam int DUTY_W = 8;

    typedef logic [LVL_W-1:0]  level_t;
    typedef logic [DUTY_W-1:0] duty_t;

    localparam level_t LVL_FULL = level_t'((1 << LVL_W) - 1);

    // Perceptual duty per level; the top level is forced on elsewhere.
    function automatic duty_t duty_of(input level_t lvl);
        duty_t d;
        case (lvl)
            4'd0:    d = 8'd0;
            4'd1:    d = 8'd1;
            4'd2:    d = 8'd3;
            4'd3:    d = 8'd6;
            4'd4:    d = 8'd10;
            4'd5:    d = 8'd16;
            4'd6:    d = 8'd24;
            4'd7:    d = 8'd34;
            4'd8:    d = 8'd47;
            4'd9:    d = 8'd64;
            4'd10:   d = 8'd86;
            4'd11:   d = 8'd113;
            4'd12:   d = 8'd145;
            4'd13:   d = 8'd178;
            4'd14:   d = 8'd217;
            default: d = 8'd255;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dim_period_ctr.sv
// Module dim_period_ctr
// Free-running PWM period counter. Flags the first and last step.
// Assumes a synchronous active-low reset that returns the count to zero.
module dim_period_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o,
    output logic             first_o,
    output logic             last_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Count steps, wrapping naturally at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o   = cnt_q;
    assign first_o = (cnt_q == '0);
    assign last_o  = (cnt_q == CNT_MAX);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));            // R2
    AST_LAST_TO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> first_o);                                           // R2

endmodule

// File: rtl/dim_level_reg.sv
// Module dim_level_reg
// Captures strobed level requests and moves the latest one into the active
// level only on the step before the counter wraps.
// Assumes last_i is high for exactly one cycle per period.
module dim_level_reg #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             last_i,
    output logic [LVL_W-1:0] act_o
);

    logic [LVL_W-1:0] pend_q;
    logic             pend_vld_q;
    logic [LVL_W-1:0] act_q;

    // Hold the newest request until the period ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
        end else if (last_i) begin
            pend_vld_q <= 1'b0;
        end else if (stb_i) begin
            pend_q     <= lvl_i;
            pend_vld_q <= 1'b1;
        end
    end

    // Apply the pending or same-cycle request at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (last_i) begin
            if (stb_i)           act_q <= lvl_i;
            else if (pend_vld_q) act_q <= pend_q;
        end
    end

    assign act_o = act_q;

    AST_LVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !last_i |=> $stable(act_q));                                   // R8
    AST_LAST_STB_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (last_i && stb_i) |=> (act_q == $past(lvl_i)));                // R10

endmodule

// File: rtl/dim_duty_map.sv
// Module dim_duty_map
// Looks up the perceptual duty for the active level and flags the level
// that forces the output fully on.
// Assumes the table in dim_pkg rises strictly from level 1 to 14.
module dim_duty_map
    import dim_pkg::*;
(
    input  level_t lvl_i,
    output duty_t  duty_o,
    output logic   full_o
);

    // Combinational table lookup and forced-on detection.
    always_comb begin
        duty_o = duty_of(lvl_i);
        full_o = (lvl_i == LVL_FULL);
    end

endmodule

// File: rtl/led_dimmer.sv
// Module led_dimmer
// Perceptual PWM dimmer for one LED: a 4-bit level is mapped through a fixed
// table to an 8-bit duty and compared with a 256-step period counter.
// Assumes a 256-step period (counter width equals duty width) and a
// synchronous active-low reset.
module led_dimmer
    import dim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level_in,
    input  logic             level_stb,
    output logic             led_out,
    output logic             period_start
);

    logic [DUTY_W-1:0] cnt;
    logic              first_step;
    logic              last_step;
    level_t            act_lvl;
    duty_t             duty;
    logic              full_on;

    dim_period_ctr #(.CNT_W(DUTY_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_o   (cnt),
        .first_o (first_step),
        .last_o  (last_step)
    );

    dim_level_reg #(.LVL_W(LVL_W)) u_lvl (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (level_stb),
        .lvl_i  (level_in),
        .last_i (last_step),
        .act_o  (act_lvl)
    );

    dim_duty_map u_map (
        .lvl_i  (act_lvl),
        .duty_o (duty),
        .full_o (full_on)
    );

    // Drive the LED high while the count is below the duty, or always if forced.
    always_comb begin
        led_out      = full_on || (cnt < duty);
        period_start = first_step;
    end

    AST_FULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (act_lvl == LVL_FULL) |-> led_out);                            // R5
    AST_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (act_lvl == '0) |-> !led_out);                                 // R4
    AST_START_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> !period_start);                               // R2
    AST_LEVEL1_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (act_lvl == 4'd1 && !period_start) |-> !led_out);              // R6

endmodule

// File: tb/led_dimmer_test.sv
`timescale 1ns/1ps
module led_dimmer_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] level_in;
    logic       level_stb;
    logic       led_out;
    logic       period_start;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    led_dimmer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .level_in     (level_in),
        .level_stb    (level_stb),
        .led_out      (led_out),
        .period_start (period_start)
    );

    // Reference duty table from R6 and R7.
    function automatic int ref_duty(input int lvl);
        case (lvl)
            0: return 0;    1: return 1;    2: return 3;    3: return 6;
            4: return 10;   5: return 16;   6: return 24;   7: return 34;
            8: return 47;   9: return 64;   10: return 86;  11: return 113;
            12: return 145; 13: return 178; 14: return 217; default: return 256;
        endcase
    endfunction

    function automatic bit ref_led(input int lvl, input int c);
        return (lvl == 15) ? 1'b1 : (c < ref_duty(lvl));
    endfunction

    function automatic string lvl_tag(input int lvl);
        if (lvl == 0)                 return "R4";
        if (lvl == 15)                return "R5";
        if (lvl == 1 || lvl == 14)    return "R6";
        return (lvl % 2) ? "R7" : "R3";
    endfunction

    // Reference state, built from the requirements.
    int    m_cnt = 0, m_act = 0, m_pend = 0, m_nstb = 0;
    bit    m_pv = 0, m_fresh = 0;
    string m_tag = "R8";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_act = 0; m_pv = 0; m_nstb = 0; m_fresh = 0;
        end else begin
            m_fresh = 0;
            if (m_cnt == 255) begin
                if (level_stb) begin
                    m_act = level_in; m_tag = "R10"; m_fresh = 1;
                end else if (m_pv) begin
                    m_act = m_pend; m_tag = (m_nstb > 1) ? "R9" : "R8"; m_fresh = 1;
                end
                m_pv = 0; m_nstb = 0;
            end else if (level_stb) begin
                m_pend = level_in; m_pv = 1; m_nstb++;
            end
            m_cnt = (m_cnt + 1) % 256;
        end
    end

    task automatic chk(input bit act, input bit exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at step %0d level %0d: actual %0b expected %0b",
                     tag, what, m_cnt, m_act, act, exp);
        end
    endtask

    task automatic check_cycle();
        chk(period_start, (m_cnt == 0), "R2", "period_start");
        chk(led_out, ref_led(m_act, m_cnt), m_fresh ? m_tag : lvl_tag(m_act), "led_out");
    endtask

    initial begin
        process::self().srandom(32'd1234);
        rst_n = 1'b0; level_stb = 1'b0; level_in = '0;
        repeat (3) @(negedge clk);
        chk(led_out, 1'b0, "R1", "led_out in reset");
        chk(period_start, 1'b1, "R1", "period_start in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(led_out, 1'b0, "R1", "led_out after reset");
        chk(period_start, 1'b0, "R1", "period_start after reset");
        for (int cyc = 0; cyc < 48 * 256; cyc++) begin
            int p;
            p = cyc / 256;
            check_cycle();
            level_stb = 1'b0;
            if (p == 0 && m_cnt == 100) begin
                level_stb = 1'b1; level_in = 4'd15;           // R8
            end else if (p == 1 && m_cnt == 255) begin
                level_stb = 1'b1; level_in = 4'd1;            // R10
            end else if (p == 2 && (m_cnt == 20 || m_cnt == 200)) begin
                level_stb = 1'b1; level_in = (m_cnt == 20) ? 4'd7 : 4'd14; // R9
            end else if (p >= 3 && p < 19 && m_cnt == 50) begin
                level_stb = 1'b1; level_in = 4'(p - 3);       // sweep, R3 R7
            end else if (p >= 19 && ($urandom % 150) == 0) begin
                level_stb = 1'b1; level_in = 4'($urandom % 16);
            end
            @(negedge clk);
        end
        // Mid-run reset returns to dark (R1).
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(led_out, 1'b0, "R1", "led_out after second reset");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule